// File: doc/BRIEF.md
# Staged Panel Timing Generator

This block produces the raster timing for a parallel display panel. From a set of configuration fields it generates a pixel clock enable, horizontal and vertical sync, a data-enable strobe and the coordinates of the current pixel. The pixel rate comes from a divider on the system clock, and a select bit can bypass the divider. The porch, pulse and size fields follow a fixed encoding. Most fields hold their count minus one. The vertical back porch is the exception and holds its count as is.

Four stages sit in front of the timing: pixel clock, synchronization, display signal and backlight PWM. Each stage has a status output. Software brings the panel up one stage at a time with single-cycle request strobes and polls each status output before it issues the next request. The stages start in the order clock, sync, display, PWM. They shut down in the order display, sync, clock, PWM. A request that arrives out of order is dropped. The display stage waits a programmable number of whole frames after sync starts. A sync shutdown waits until the current frame has finished.

Top module: `lcd_seq_timing`

## Requirements
- R1: While reset is held, all four status outputs, `de` and `pix_ce` are 0. `hsync` equals `cfg_hpol` and `vsync` equals `cfg_vpol`.
- R2: A start request raises its status output at the next clock edge, but only when the preceding stage is already active. `req_sync_on` needs `st_clk`, `req_disp_on` needs `st_sync` and `req_pwm_on` needs `st_disp`. Without that condition the request is dropped and the status does not change. `req_clk_on` always takes effect.
- R3: `req_disp_off` clears the display stage at the next edge. `req_sync_off` is dropped while the display stage is active or waiting to start. `req_clk_off` is dropped while `st_sync` is 1. `req_pwm_off` is dropped while `st_clk` is 1.
- R4: An accepted `req_sync_off` does not clear `st_sync` at once. `st_sync` clears on the clock edge that ends the last pixel of the current frame.
- R5: While `st_clk` is 1 and `cfg_bypass` is 0, `pix_ce` pulses for one cycle in every `cfg_div`+2 system cycles. With `cfg_bypass` at 1 it is high on every cycle. While `st_clk` is 0 it stays low.
- R6: A line lasts (`cfg_hpw`+1)+(`cfg_hbp`+1)+(`cfg_ppl`+1)+(`cfg_hfp`+1) pixel clocks. The line is laid out as sync pulse, back porch, active pixels, front porch. The sync pulse is asserted for the first `cfg_hpw`+1 pixel clocks. The counters run only while `st_sync` is 1.
- R7: A frame lasts (`cfg_vpw`+1)+`cfg_vbp`+(`cfg_rows`+1)+(`cfg_vfp`+1) lines, in the same order. The vertical back porch field is not offset by one. The vertical pulse covers the first `cfg_vpw`+1 lines.
- R8: `de` is 1 only while `st_disp` is 1 and the position is inside the active rectangle. Inside that rectangle `pix_x` and `pix_y` count from 0 at its top-left corner. Outside it both read 0.
- R9: A polarity bit of 1 inverts the matching sync output, so the idle level equals the polarity bit.
- R10: The display stage becomes active only once at least `cfg_guard` frames have ended since `st_sync` rose. If enough frames have already ended when the request arrives, it becomes active at the next edge. Otherwise it becomes active one cycle after the frame end that reaches the count.
- R11: `lane_mask` has its low N bits set, where `cfg_bpp` encodes N as 0→12, 1→16, 2→18, 3→24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | DIV_W | Divider value: cycles per pixel minus 2 |
| cfg_bypass | input | 1 | 1: pixel enable on every system cycle |
| cfg_hpw | input | TW | Horizontal pulse width minus one |
| cfg_hbp | input | TW | Horizontal back porch minus one |
| cfg_ppl | input | TW | Pixels per line minus one |
| cfg_hfp | input | TW | Horizontal front porch minus one |
| cfg_vpw | input | TW | Vertical pulse width minus one |
| cfg_vbp | input | TW | Vertical back porch, stored directly |
| cfg_rows | input | TW | Rows per frame minus one |
| cfg_vfp | input | TW | Vertical front porch minus one |
| cfg_hpol | input | 1 | Invert horizontal sync |
| cfg_vpol | input | 1 | Invert vertical sync |
| cfg_guard | input | GW | Frames to wait between sync start and display start |
| cfg_bpp | input | 2 | Output width code |
| req_clk_on | input | 1 | Start pixel clock stage |
| req_sync_on | input | 1 | Start sync stage |
| req_disp_on | input | 1 | Start display stage |
| req_pwm_on | input | 1 | Start PWM stage |
| req_disp_off | input | 1 | Stop display stage |
| req_sync_off | input | 1 | Stop sync stage at end of frame |
| req_clk_off | input | 1 | Stop pixel clock stage |
| req_pwm_off | input | 1 | Stop PWM stage |
| pix_ce | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | TW | Column inside the active area |
| pix_y | output | TW | Row inside the active area |
| lane_mask | output | 24 | Driven pixel data lanes |
| st_clk | output | 1 | Pixel clock stage active |
| st_sync | output | 1 | Sync stage active |
| st_disp | output | 1 | Display stage active |
| st_pwm | output | 1 | PWM stage active |

## Verification
The assertions assume that at most one request strobe is high in any cycle. They also assume that the divider, bypass and timing fields stay constant while the clock stage is active, because the counter bounds and the pixel-enable spacing are only meaningful under a fixed configuration. The stimulus pulses each request alone for a single cycle. It changes the configuration only after every stage has been shut down. It covers three configurations: divided clock with guard 1, bypass with inverted polarities and guard 0, and the shortest divider with guard 2.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int LANES = 24;

    typedef struct packed {
        logic clk_on;
        logic sync_on;
        logic disp_on;
        logic pwm_on;
    } stage_t;

    function automatic logic [LANES-1:0] lane_mask_f(input logic [1:0] code);
        logic [LANES-1:0] m;
        case (code)
            2'd0:    m = 24'h000fff;
            2'd1:    m = 24'h00ffff;
            2'd2:    m = 24'h03ffff;
            default: m = 24'hffffff;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             bypass,
    input  logic [DIV_W-1:0] div,
    output logic             pix_ce
);
    localparam int CW = DIV_W + 1;
    localparam logic [CW-1:0] ONE = 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          wrap;

    always_comb begin
        wrap   = (cnt_q == CW'(div) + ONE);
        pix_ce = run && (bypass || wrap);
        if (!run || bypass || wrap) cnt_d = '0;
        else                        cnt_d = cnt_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: a divided enable never fires on two cycles in a row
    a_r5_ce_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ce && !bypass) |=> !pix_ce);

    // R5: the divider counter never passes its wrap point
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(div) |-> (cnt_q <= CW'(div) + ONE));

endmodule

// File: rtl/lcdt_raster.sv
module lcdt_raster #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          ce,
    input  logic          disp_on,
    input  logic [TW-1:0] hpw,
    input  logic [TW-1:0] hbp,
    input  logic [TW-1:0] ppl,
    input  logic [TW-1:0] hfp,
    input  logic [TW-1:0] vpw,
    input  logic [TW-1:0] vbp,
    input  logic [TW-1:0] rows,
    input  logic [TW-1:0] vfp,
    input  logic          hpol,
    input  logic          vpol,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [TW-1:0] pix_x,
    output logic [TW-1:0] pix_y,
    output logic          frame_end
);
    localparam int CW = TW + 3;
    localparam logic [CW-1:0] ONE = 1;

    typedef struct packed {
        logic [CW-1:0] h;
        logic [CW-1:0] v;
    } pos_t;

    pos_t          d, q;
    logic [CW-1:0] hs_end, ha_beg, ha_end, htot;
    logic [CW-1:0] vs_end, va_beg, va_end, vtot;
    logic          in_h, in_v, h_last, v_last;

    always_comb begin
        hs_end = CW'(hpw) + ONE;
        ha_beg = hs_end + CW'(hbp) + ONE;
        ha_end = ha_beg + CW'(ppl) + ONE;
        htot   = ha_end + CW'(hfp) + ONE;
        vs_end = CW'(vpw) + ONE;
        va_beg = vs_end + CW'(vbp);
        va_end = va_beg + CW'(rows) + ONE;
        vtot   = va_end + CW'(vfp) + ONE;

        in_h   = (q.h >= ha_beg) && (q.h < ha_end);
        in_v   = (q.v >= va_beg) && (q.v < va_end);
        h_last = (q.h == htot - ONE);
        v_last = (q.v == vtot - ONE);
        frame_end = run && ce && h_last && v_last;

        d = q;
        if (!run) begin
            d = '0;
        end else if (ce) begin
            if (h_last) begin
                d.h = '0;
                d.v = v_last ? '0 : q.v + ONE;
            end else begin
                d.h = q.h + ONE;
            end
        end

        hsync = (run && (q.h < hs_end)) ^ hpol;
        vsync = (run && (q.v < vs_end)) ^ vpol;
        de    = disp_on && in_h && in_v;
        pix_x = (in_h && in_v) ? TW'(q.h - ha_beg) : '0;
        pix_y = (in_h && in_v) ? TW'(q.v - va_beg) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: data enable only while the display stage reports active
    a_r8_de_needs_disp: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> disp_on);

    // R6: horizontal position stays inside the programmed line
    a_r6_h_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $stable({hpw, hbp, ppl, hfp}) |-> (q.h < htot));

    // R7: counters rest at the origin while sync is off
    a_r7_idle_origin: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (q.h == '0 && q.v == '0));

endmodule

// File: rtl/lcdt_seq.sv
module lcdt_seq #(
    parameter int GW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_clk_on,
    input  logic            req_sync_on,
    input  logic            req_disp_on,
    input  logic            req_pwm_on,
    input  logic            req_disp_off,
    input  logic            req_sync_off,
    input  logic            req_clk_off,
    input  logic            req_pwm_off,
    input  logic            frame_end,
    input  logic [GW-1:0]   guard,
    output lcdt_pkg::stage_t st
);
    typedef struct packed {
        lcdt_pkg::stage_t s;
        logic             disp_pend;
        logic             sync_drain;
        logic [GW-1:0]    frames;
    } seq_t;

    seq_t d, q;
    logic guard_met;

    always_comb begin
        d = q;
        guard_met = (q.frames >= guard);

        if (!q.s.sync_on)                     d.frames = '0;
        else if (frame_end && q.frames != '1) d.frames = q.frames + 1'b1;

        if (req_clk_on)                       d.s.clk_on = 1'b1;
        if (req_clk_off && !q.s.sync_on)      d.s.clk_on = 1'b0;

        if (req_sync_on && q.s.clk_on && !q.s.sync_on) d.s.sync_on = 1'b1;
        if (req_sync_off && q.s.sync_on && !q.s.disp_on && !q.disp_pend)
            d.sync_drain = 1'b1;
        if (q.sync_drain && frame_end) begin
            d.s.sync_on  = 1'b0;
            d.sync_drain = 1'b0;
        end

        if (q.disp_pend && guard_met) begin
            d.s.disp_on = 1'b1;
            d.disp_pend = 1'b0;
        end
        if (req_disp_on && q.s.sync_on && !q.s.disp_on && !q.sync_drain) begin
            if (guard_met) d.s.disp_on = 1'b1;
            else           d.disp_pend = 1'b1;
        end
        if (req_disp_off) begin
            d.s.disp_on = 1'b0;
            d.disp_pend = 1'b0;
        end

        if (req_pwm_on && q.s.disp_on)       d.s.pwm_on = 1'b1;
        if (req_pwm_off && !q.s.clk_on)      d.s.pwm_on = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign st = q.s;

    // R2: sync is never active without the pixel clock
    a_r2_sync_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
        st.sync_on |-> st.clk_on);

    // R2: display is never active without sync
    a_r2_disp_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
        st.disp_on |-> st.sync_on);

    // R2: PWM can only start while the display stage is up
    a_r2_pwm_after_disp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st.pwm_on) |-> $past(st.disp_on));

    // R4: sync only drops on the last pixel of a frame
    a_r4_sync_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st.sync_on) |-> $past(frame_end));

    // R3: the pixel clock only stops once sync is down
    a_r3_clk_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st.clk_on) |-> !$past(st.sync_on));

endmodule

// File: rtl/lcd_seq_timing.sv
module lcd_seq_timing #(
    parameter int DIV_W = 8,
    parameter int TW    = 8,
    parameter int GW    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DIV_W-1:0]           cfg_div,
    input  logic                       cfg_bypass,
    input  logic [TW-1:0]              cfg_hpw,
    input  logic [TW-1:0]              cfg_hbp,
    input  logic [TW-1:0]              cfg_ppl,
    input  logic [TW-1:0]              cfg_hfp,
    input  logic [TW-1:0]              cfg_vpw,
    input  logic [TW-1:0]              cfg_vbp,
    input  logic [TW-1:0]              cfg_rows,
    input  logic [TW-1:0]              cfg_vfp,
    input  logic                       cfg_hpol,
    input  logic                       cfg_vpol,
    input  logic [GW-1:0]              cfg_guard,
    input  logic [1:0]                 cfg_bpp,
    input  logic                       req_clk_on,
    input  logic                       req_sync_on,
    input  logic                       req_disp_on,
    input  logic                       req_pwm_on,
    input  logic                       req_disp_off,
    input  logic                       req_sync_off,
    input  logic                       req_clk_off,
    input  logic                       req_pwm_off,
    output logic                       pix_ce,
    output logic                       hsync,
    output logic                       vsync,
    output logic                       de,
    output logic [TW-1:0]              pix_x,
    output logic [TW-1:0]              pix_y,
    output logic [lcdt_pkg::LANES-1:0] lane_mask,
    output logic                       st_clk,
    output logic                       st_sync,
    output logic                       st_disp,
    output logic                       st_pwm
);
    lcdt_pkg::stage_t st;
    logic             frame_end;

    lcdt_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st.clk_on),
        .bypass (cfg_bypass),
        .div    (cfg_div),
        .pix_ce (pix_ce)
    );

    lcdt_raster #(.TW(TW)) u_raster (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (st.sync_on),
        .ce        (pix_ce),
        .disp_on   (st.disp_on),
        .hpw       (cfg_hpw),
        .hbp       (cfg_hbp),
        .ppl       (cfg_ppl),
        .hfp       (cfg_hfp),
        .vpw       (cfg_vpw),
        .vbp       (cfg_vbp),
        .rows      (cfg_rows),
        .vfp       (cfg_vfp),
        .hpol      (cfg_hpol),
        .vpol      (cfg_vpol),
        .hsync     (hsync),
        .vsync     (vsync),
        .de        (de),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .frame_end (frame_end)
    );

    lcdt_seq #(.GW(GW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_clk_on   (req_clk_on),
        .req_sync_on  (req_sync_on),
        .req_disp_on  (req_disp_on),
        .req_pwm_on   (req_pwm_on),
        .req_disp_off (req_disp_off),
        .req_sync_off (req_sync_off),
        .req_clk_off  (req_clk_off),
        .req_pwm_off  (req_pwm_off),
        .frame_end    (frame_end),
        .guard        (cfg_guard),
        .st           (st)
    );

    assign lane_mask = lcdt_pkg::lane_mask_f(cfg_bpp);
    assign st_clk    = st.clk_on;
    assign st_sync   = st.sync_on;
    assign st_disp   = st.disp_on;
    assign st_pwm    = st.pwm_on;

    // R11: the lane mask is a contiguous run from bit 0
    a_r11_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_mask & (lane_mask + 24'd1)) == '0) && lane_mask[11:0] == 12'hfff);

endmodule

// File: tb/lcd_seq_timing_bench.sv
module lcd_seq_timing_bench;
    localparam int DIV_W = 8;
    localparam int TW    = 8;
    localparam int GW    = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic [DIV_W-1:0] cfg_div;
    logic cfg_bypass, cfg_hpol, cfg_vpol;
    logic [TW-1:0] cfg_hpw, cfg_hbp, cfg_ppl, cfg_hfp, cfg_vpw, cfg_vbp, cfg_rows, cfg_vfp;
    logic [GW-1:0] cfg_guard;
    logic [1:0] cfg_bpp;
    logic rq_con, rq_son, rq_don, rq_pon, rq_doff, rq_soff, rq_coff, rq_poff;
    logic pix_ce, hsync, vsync, de, st_clk, st_sync, st_disp, st_pwm;
    logic [TW-1:0] pix_x, pix_y;
    logic [23:0] lane_mask;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    lcd_seq_timing #(.DIV_W(DIV_W), .TW(TW), .GW(GW)) u_lcd_seq_timing (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_bypass(cfg_bypass),
        .cfg_hpw(cfg_hpw), .cfg_hbp(cfg_hbp), .cfg_ppl(cfg_ppl), .cfg_hfp(cfg_hfp),
        .cfg_vpw(cfg_vpw), .cfg_vbp(cfg_vbp), .cfg_rows(cfg_rows), .cfg_vfp(cfg_vfp),
        .cfg_hpol(cfg_hpol), .cfg_vpol(cfg_vpol), .cfg_guard(cfg_guard), .cfg_bpp(cfg_bpp),
        .req_clk_on(rq_con), .req_sync_on(rq_son), .req_disp_on(rq_don), .req_pwm_on(rq_pon),
        .req_disp_off(rq_doff), .req_sync_off(rq_soff), .req_clk_off(rq_coff), .req_pwm_off(rq_poff),
        .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
        .lane_mask(lane_mask), .st_clk(st_clk), .st_sync(st_sync), .st_disp(st_disp), .st_pwm(st_pwm)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_dc, m_h, m_v, m_fr;
    bit m_clk, m_sync, m_disp, m_pwm, m_pend, m_drain;
    int hw1, hb1, act_w, hf1, vw1, vb0, act_h, vf1, line_len, frame_len;
    bit m_ce, m_fe, o_clk, o_sync, o_disp, o_pend, o_drain;

    function automatic bit ce_now();
        return m_clk && (cfg_bypass || m_dc == int'(cfg_div) + 1);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dc = 0; m_h = 0; m_v = 0; m_fr = 0;
            m_clk = 0; m_sync = 0; m_disp = 0; m_pwm = 0; m_pend = 0; m_drain = 0;
        end else begin
            hw1 = cfg_hpw + 1; hb1 = cfg_hbp + 1; act_w = cfg_ppl + 1; hf1 = cfg_hfp + 1;
            vw1 = cfg_vpw + 1; vb0 = cfg_vbp; act_h = cfg_rows + 1; vf1 = cfg_vfp + 1;
            line_len = hw1 + hb1 + act_w + hf1;
            frame_len = vw1 + vb0 + act_h + vf1;
            m_ce = ce_now();
            m_fe = m_ce && m_sync && m_h == line_len - 1 && m_v == frame_len - 1;
            o_clk = m_clk; o_sync = m_sync; o_disp = m_disp; o_pend = m_pend; o_drain = m_drain;

            if (!m_clk || cfg_bypass || m_dc == int'(cfg_div) + 1) m_dc = 0;
            else m_dc++;

            if (!o_sync) begin m_h = 0; m_v = 0; end
            else if (m_ce) begin
                m_h++;
                if (m_h == line_len) begin
                    m_h = 0; m_v++;
                    if (m_v == frame_len) m_v = 0;
                end
            end

            if (!o_sync) m_fr = 0;
            else if (m_fe && m_fr < (1 << GW) - 1) m_fr++;

            if (rq_con) m_clk = 1;
            if (rq_coff && !o_sync) m_clk = 0;
            if (rq_son && o_clk && !o_sync) m_sync = 1;
            if (rq_soff && o_sync && !o_disp && !o_pend) m_drain = 1;
            if (o_drain && m_fe) begin m_sync = 0; m_drain = 0; end
            if (o_pend && m_fr_prev_ok()) begin m_disp = 1; m_pend = 0; end
            if (rq_don && o_sync && !o_disp && !o_drain) begin
                if (m_fr_prev_ok()) m_disp = 1; else m_pend = 1;
            end
            if (rq_doff) begin m_disp = 0; m_pend = 0; end
            if (rq_pon && o_disp) m_pwm = 1;
            if (rq_poff && !o_clk) m_pwm = 0;
        end
    end

    // frame count before this edge is what gates the display start
    int fr_before;
    always @(negedge clk) fr_before = m_fr;
    function automatic bit m_fr_prev_ok();
        return fr_before >= int'(cfg_guard);
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            int hab, vab, bits;
            bit inh, inv;
            #1;
            hab = cfg_hpw + cfg_hbp + 2;
            vab = cfg_vpw + 1 + cfg_vbp;
            inh = m_h >= hab && m_h < hab + cfg_ppl + 1;
            inv = m_v >= vab && m_v < vab + cfg_rows + 1;
            chk("R5 pixel enable", pix_ce, ce_now());
            chk(cfg_hpol ? "R9 hsync inverted" : "R6 hsync", hsync,
                int'((m_sync && m_h < cfg_hpw + 1) ^ cfg_hpol));
            chk(cfg_vpol ? "R9 vsync inverted" : "R7 vsync", vsync,
                int'((m_sync && m_v < cfg_vpw + 1) ^ cfg_vpol));
            chk("R8 data enable", de, int'(m_disp && inh && inv));
            chk("R8 pix_x", pix_x, (inh && inv) ? m_h - hab : 0);
            chk("R8 pix_y", pix_y, (inh && inv) ? m_v - vab : 0);
            chk("R2 st_clk", st_clk, m_clk);
            chk("R4 st_sync", st_sync, m_sync);
            chk("R10 st_disp", st_disp, m_disp);
            chk("R3 st_pwm", st_pwm, m_pwm);
            bits = (cfg_bpp == 0) ? 12 : (cfg_bpp == 1) ? 16 : (cfg_bpp == 2) ? 18 : 24;
            chk("R11 lane mask", int'(lane_mask), (1 << bits) - 1);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: rq_con = 1; 1: rq_son = 1; 2: rq_don = 1; 3: rq_pon = 1;
            4: rq_doff = 1; 5: rq_soff = 1; 6: rq_coff = 1; default: rq_poff = 1;
        endcase
        @(negedge clk);
        {rq_con, rq_son, rq_don, rq_pon, rq_doff, rq_soff, rq_coff, rq_poff} = '0;
    endtask

    task automatic all_off();
        strobe(4); idle(2);
        strobe(5); idle(400);
        chk("R4 sync cleared after frame", st_sync, 0);
        strobe(6); idle(2);
        strobe(7); idle(2);
        chk("R3 all stages down", {st_clk, st_pwm}, 0);
    endtask

    initial begin
        rst_n = 0;
        {rq_con, rq_son, rq_don, rq_pon, rq_doff, rq_soff, rq_coff, rq_poff} = '0;
        cfg_div = 1; cfg_bypass = 0; cfg_hpol = 0; cfg_vpol = 0; cfg_guard = 1; cfg_bpp = 3;
        cfg_hpw = 1; cfg_hbp = 0; cfg_ppl = 3; cfg_hfp = 0;
        cfg_vpw = 0; cfg_vbp = 1; cfg_rows = 2; cfg_vfp = 0;
        idle(3);
        chk("R1 reset status", {st_clk, st_sync, st_disp, st_pwm}, 0);
        chk("R1 reset de/ce", {de, pix_ce}, 0);
        chk("R1 reset sync idle", {hsync, vsync}, {cfg_hpol, cfg_vpol});
        rst_n = 1;
        for (int m = 0; m < 4; m++) begin
            cfg_bpp = m[1:0];
            idle(2);
        end

        // configuration A: divided clock, guard 1
        strobe(1); idle(2); chk("R2 sync-on dropped without clock", st_sync, 0);
        strobe(2); idle(2); chk("R2 disp-on dropped without sync", st_disp, 0);
        strobe(0); idle(2); chk("R2 clock on", st_clk, 1);
        strobe(3); idle(2); chk("R2 pwm-on dropped without display", st_pwm, 0);
        strobe(1); idle(2); chk("R2 sync on", st_sync, 1);
        strobe(6); idle(2); chk("R3 clk-off dropped while sync", st_clk, 1);
        strobe(2); idle(2); chk("R10 display waits guard frame", st_disp, 0);
        idle(300); chk("R10 display after guard", st_disp, 1);
        strobe(3); idle(2); chk("R2 pwm on", st_pwm, 1);
        strobe(5); idle(200); chk("R3 sync-off dropped while display", st_sync, 1);
        strobe(7); idle(2); chk("R3 pwm-off dropped while clock", st_pwm, 1);
        all_off();

        // configuration B: bypass, inverted polarity, guard 0
        cfg_bypass = 1; cfg_hpol = 1; cfg_vpol = 1; cfg_guard = 0;
        cfg_hpw = 0; cfg_hbp = 2; cfg_ppl = 5; cfg_hfp = 2;
        cfg_vpw = 1; cfg_vbp = 0; cfg_rows = 1; cfg_vfp = 1;
        idle(2);
        strobe(0); idle(1); strobe(1); idle(1);
        strobe(2); chk("R10 guard zero immediate", st_disp, 1);
        strobe(3); idle(300);
        all_off();

        // configuration C: shortest divider, guard 2
        cfg_bypass = 0; cfg_div = 0; cfg_hpol = 0; cfg_vpol = 0; cfg_guard = 2;
        cfg_hpw = 1; cfg_hbp = 0; cfg_ppl = 3; cfg_hfp = 0;
        cfg_vpw = 0; cfg_vbp = 1; cfg_rows = 2; cfg_vfp = 0;
        idle(2);
        strobe(0); idle(1); strobe(1); idle(1);
        strobe(2); idle(100); chk("R10 one frame is not enough", st_disp, 0);
        idle(200); chk("R10 display after two frames", st_disp, 1);
        all_off();

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule